// File: doc/BRIEF.md
# Paged Nonvolatile Memory Controller

This block sits between a register-access bus engine and a modelled nonvolatile byte array. The array holds 1024 bytes at word addresses 0xF800 through 0xFBFF, organised as 32 pages of 32 bytes. A bank of 224 volatile shadow registers sits at 0x00 through 0xDF. The bus engine issues one request at a time: read, write or page erase. Each request gets exactly one response in the following cycle: acknowledge, reject, or read data.

Nonvolatile bytes follow flash-like rules. A byte can be programmed only while it holds the blank value 0xFF. Blank values come back only through an erase of the whole page. Erases obey an enable bit held in a shadow register. Program and erase latencies are counted in clock cycles. During that time `busy` is raised so that the bus engine can stretch the clock or NACK. Every request that arrives while busy is rejected.

At reset, and again when software sets bit 0 of the download register, the first seven pages are copied byte by byte into the shadow registers. No access is allowed until the copy finishes.

Top module: `nvm_page_ctrl`

## Requirements
- R1: From reset, `busy` is high and the copy of nonvolatile bytes 0..223 into shadow registers 0x00..0xDF runs one byte per cycle. `busy` stays high for 224 cycles after reset is released. Afterwards each shadow register holds the byte at 0xF800 plus its address. An unwritten array reads 0xFF.
- R2: A read (`req_op`=0) of an address in 0xF800..0xFBFF returns the stored byte on `rd_data` with `rd_valid` one cycle after the request.
- R3: A write (`req_op`=1) to a blank (0xFF) nonvolatile byte is acknowledged. `busy` then stays high for PROG_CYCLES cycles, and after that the byte reads back as the written value.
- R4: A write to a nonvolatile byte that is not 0xFF is rejected and leaves the byte unchanged. It also sets `prog_err`, which stays high until reset.
- R5: An erase (`req_op`=2) is acknowledged when bit 2 of shadow register 0x90 is 1. Address bits [9:5] select the page and bits [4:0] are ignored. `busy` stays high for ERASE_CYCLES cycles, after which all 32 bytes of that page read 0xFF and other pages are unchanged.
- R6: An erase while bit 2 of shadow register 0x90 is 0 is rejected and changes no byte.
- R7: Any request while `busy` is high is rejected and has no effect.
- R8: A request is rejected with no effect in any of these cases: the address is outside both 0x00..0xDF and 0xF800..0xFBFF, the request is an erase aimed at a shadow address, or `req_op`=3.
- R9: Shadow registers 0x00..0xDF are written with acknowledge and no busy time, and they read back on `rd_valid` one cycle after the request.
- R10: A write to shadow register 0xD8 with data bit 0 set is acknowledged and then repeats the R1 copy. `busy` is high for 224 cycles and the shadow registers end up equal to nonvolatile bytes 0..223.
- R11: Each request cycle produces exactly one of `rsp_ack`, `rsp_nak`, `rd_valid` in the next cycle. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 page erase, 3 reserved |
| req_addr | input | 16 | Word address of the request |
| req_wdata | input | 8 | Write data |
| rsp_ack | output | 1 | Request accepted (write or erase) |
| rsp_nak | output | 1 | Request rejected |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Copy, program or erase in progress |
| prog_err | output | 1 | Sticky flag: write aimed at a non-blank byte |

## Verification
The assertions assume that `req_valid` is never unknown once reset is released. They also assume that request fields are steady during the clock edge that samples them, and that the engine issues at most one request per cycle with no retry of its own. The stimulus meets these assumptions: it changes inputs only on falling edges, raises `req_valid` for exactly one cycle per request, and issues the requests made during busy periods on purpose, to exercise rejection.

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int NV_PAGES     = 32,
  parameter int CFG_PAGES    = 7,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40,
  parameter logic [ADDR_W-1:0] NV_BASE      = 16'hF800,
  parameter logic [ADDR_W-1:0] ERASE_EN_REG = 16'h0090,
  parameter logic [ADDR_W-1:0] DNLD_REG     = 16'h00D8,
  parameter int ERASE_EN_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ack,
  output logic              rsp_nak,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              prog_err
);
  localparam int NV_BYTES = PAGE_BYTES * NV_PAGES;
  localparam int NV_AW    = $clog2(NV_BYTES);
  localparam int PG_AW    = $clog2(PAGE_BYTES);
  localparam int SH_BYTES = PAGE_BYTES * CFG_PAGES;
  localparam int SH_AW    = $clog2(SH_BYTES);
  localparam int CNT_MAX  = (ERASE_CYCLES > SH_BYTES) ?
                            ((ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES) :
                            ((SH_BYTES > PROG_CYCLES) ? SH_BYTES : PROG_CYCLES);
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {M_IDLE, M_COPY, M_PROG, M_ERASE} mode_t;

  mode_t             mode;
  logic [CNT_W-1:0]  cnt;
  logic [NV_AW-1:0]  pend_idx;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] nv_mem [NV_BYTES];
  logic [DATA_W-1:0] shadow [SH_BYTES];

  logic             nv_hit, ram_hit, erase_en;
  logic [NV_AW-1:0] nv_idx;
  logic [SH_AW-1:0] sh_idx, cp_idx;

  assign nv_hit   = (req_addr >> NV_AW) == (NV_BASE >> NV_AW);
  assign ram_hit  = req_addr < ADDR_W'(SH_BYTES);
  assign nv_idx   = req_addr[NV_AW-1:0];
  assign sh_idx   = req_addr[SH_AW-1:0];
  assign cp_idx   = cnt[SH_AW-1:0];
  assign erase_en = shadow[ERASE_EN_REG[SH_AW-1:0]][ERASE_EN_BIT];
  assign busy     = mode != M_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_COPY;
      cnt       <= '0;
      rsp_ack   <= 1'b0;
      rsp_nak   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      prog_err  <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
      for (int i = 0; i < NV_BYTES; i++) nv_mem[i] <= '1;
      for (int i = 0; i < SH_BYTES; i++) shadow[i] <= '0;
    end else begin
      rsp_ack  <= 1'b0;
      rsp_nak  <= 1'b0;
      rd_valid <= 1'b0;

      case (mode)
        M_COPY: begin
          shadow[cp_idx] <= nv_mem[NV_AW'(cp_idx)];
          if (cnt == CNT_W'(SH_BYTES - 1)) begin
            mode <= M_IDLE;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        M_PROG, M_ERASE: begin
          if (cnt == '0) begin
            mode <= M_IDLE;
            if (mode == M_PROG)
              nv_mem[pend_idx] <= pend_data;
            else
              for (int i = 0; i < PAGE_BYTES; i++)
                nv_mem[{pend_idx[NV_AW-1:PG_AW], PG_AW'(i)}] <= '1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase

      if (req_valid) begin
        if (busy) begin
          rsp_nak <= 1'b1;
        end else begin
          case (req_op)
            2'd0: begin
              if (nv_hit) begin
                rd_valid <= 1'b1;
                rd_data  <= nv_mem[nv_idx];
              end else if (ram_hit) begin
                rd_valid <= 1'b1;
                rd_data  <= shadow[sh_idx];
              end else begin
                rsp_nak <= 1'b1;
              end
            end
            2'd1: begin
              if (nv_hit) begin
                if (nv_mem[nv_idx] != '1) begin
                  rsp_nak  <= 1'b1;
                  prog_err <= 1'b1;
                end else begin
                  rsp_ack   <= 1'b1;
                  mode      <= M_PROG;
                  cnt       <= CNT_W'(PROG_CYCLES - 1);
                  pend_idx  <= nv_idx;
                  pend_data <= req_wdata;
                end
              end else if (ram_hit) begin
                rsp_ack        <= 1'b1;
                shadow[sh_idx] <= req_wdata;
                if (req_addr == DNLD_REG && req_wdata[0]) begin
                  mode <= M_COPY;
                  cnt  <= '0;
                end
              end else begin
                rsp_nak <= 1'b1;
              end
            end
            2'd2: begin
              if (nv_hit && erase_en) begin
                rsp_ack  <= 1'b1;
                mode     <= M_ERASE;
                cnt      <= CNT_W'(ERASE_CYCLES - 1);
                pend_idx <= nv_idx;
              end else begin
                rsp_nak <= 1'b1;
              end
            end
            default: rsp_nak <= 1'b1;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/nvm_page_ctrl_chk.sv
module nvm_page_ctrl_chk #(
  parameter logic [15:0] SH_LIMIT = 16'h00E0,
  parameter logic [15:0] NV_LO    = 16'hF800,
  parameter logic [15:0] NV_HI    = 16'hFBFF,
  parameter logic [15:0] DNLD     = 16'h00D8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic [15:0] req_addr,
  input logic        rsp_ack,
  input logic        rsp_nak,
  input logic        rd_valid,
  input logic        busy,
  input logic        prog_err
);
  logic in_nv, in_sh;
  assign in_nv = req_addr >= NV_LO && req_addr <= NV_HI;
  assign in_sh = req_addr < SH_LIMIT;

  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({rsp_ack, rsp_nak, rd_valid}) == 1); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_ack || rsp_nak || rd_valid)); // R11
  AST_BUSY_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && busy |=> rsp_nak); // R7
  AST_OOR_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !in_nv && !in_sh |=> rsp_nak); // R8
  AST_RSVD_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd3 |=> rsp_nak); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |=> prog_err); // R4
  AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd2 |=> (!rsp_ack || busy)); // R5
  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd1 && in_nv |=> (!rsp_ack || busy)); // R3
  AST_RAM_NOBUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && req_op == 2'd1 && in_sh && req_addr != DNLD |=> !busy); // R9
endmodule

bind nvm_page_ctrl nvm_page_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .rsp_ack(rsp_ack), .rsp_nak(rsp_nak),
  .rd_valid(rd_valid), .busy(busy), .prog_err(prog_err)
);

// File: tb/nvm_page_ctrl_tb.sv
module nvm_page_ctrl_tb;
  localparam int PROG_C  = 8;
  localparam int ERASE_C = 40;
  localparam int COPY_C  = 224;
  localparam logic [1:0] K_ACK = 2'd0, K_NAK = 2'd1, K_DAT = 2'd2;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_op = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic rsp_ack, rsp_nak, rd_valid, busy, prog_err;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [9:0] expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  nvm_page_ctrl #(.PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(rsp_ack),
    .rsp_nak(rsp_nak), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .prog_err(prog_err));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (rsp_ack || rsp_nak || rd_valid)) begin
      logic [1:0] k;
      logic [9:0] e;
      string t;
      k = rsp_ack ? K_ACK : (rsp_nak ? K_NAK : K_DAT);
      if (expq.size() == 0) begin
        check("R11 unexpected response", 32'(k), 32'hF);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        check({t, " kind"}, 32'(k), 32'(e[9:8]));
        if (e[9:8] == K_DAT) check({t, " data"}, 32'(rd_data), 32'(e[7:0]));
      end
    end
  end

  task automatic do_req(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                        input logic [1:0] k, input logic [7:0] ed, input string tag);
    expq.push_back({k, ed});
    tagq.push_back(tag);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic busy_len(input int exp, input string tag);
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(tag, 32'(n), 32'(exp));
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 1);
    check("R11 no response in reset", 32'({rsp_ack, rsp_nak, rd_valid}), 0);
    check("R4 prog_err clear at reset", 32'(prog_err), 0);
    rst_n = 1;
    busy_len(COPY_C, "R1 power-up copy length");

    do_req(0, 16'hF800, 0, K_DAT, 8'hFF, "R2 blank read");
    do_req(0, 16'h0000, 0, K_DAT, 8'hFF, "R1 shadow 0x00 copied");
    do_req(0, 16'h00DF, 0, K_DAT, 8'hFF, "R1 shadow 0xDF copied");

    do_req(1, 16'h0010, 8'h5A, K_ACK, 0, "R9 ram write");
    check("R9 no busy", 32'(busy), 0);
    do_req(0, 16'h0010, 0, K_DAT, 8'h5A, "R9 ram read");

    do_req(1, 16'hF805, 8'h3C, K_ACK, 0, "R3 program blank");
    busy_len(PROG_C, "R3 program busy length");
    do_req(0, 16'hF805, 0, K_DAT, 8'h3C, "R3 readback");

    do_req(1, 16'hF805, 8'h00, K_NAK, 0, "R4 program non-blank");
    check("R4 prog_err set", 32'(prog_err), 1);
    do_req(0, 16'hF805, 0, K_DAT, 8'h3C, "R4 byte unchanged");

    do_req(1, 16'hF9E1, 8'h77, K_ACK, 0, "R3 program region 1");
    wait_idle();
    do_req(1, 16'hF820, 8'h66, K_ACK, 0, "R3 program page 1");
    wait_idle();

    do_req(1, 16'h0090, 8'h00, K_ACK, 0, "R6 clear erase enable");
    do_req(2, 16'hF805, 0, K_NAK, 0, "R6 erase disabled");
    check("R6 no busy", 32'(busy), 0);
    do_req(0, 16'hF805, 0, K_DAT, 8'h3C, "R6 byte unchanged");

    do_req(1, 16'h0090, 8'h04, K_ACK, 0, "R5 set erase enable");
    do_req(2, 16'hF81F, 0, K_ACK, 0, "R5 erase page 0 via low bits");
    busy_len(ERASE_C, "R5 erase busy length");
    do_req(0, 16'hF805, 0, K_DAT, 8'hFF, "R5 erased byte");
    do_req(0, 16'hF820, 0, K_DAT, 8'h66, "R5 next page kept");
    do_req(0, 16'hF9E1, 0, K_DAT, 8'h77, "R5 other region kept");

    do_req(0, 16'h00E0, 0, K_NAK, 0, "R8 read 0xE0");
    do_req(0, 16'hF7FF, 0, K_NAK, 0, "R8 read 0xF7FF");
    do_req(1, 16'hFC00, 8'h01, K_NAK, 0, "R8 write 0xFC00");
    do_req(2, 16'h0010, 0, K_NAK, 0, "R8 erase shadow");
    do_req(3, 16'hF800, 0, K_NAK, 0, "R8 reserved op");
    do_req(0, 16'h0010, 0, K_DAT, 8'h5A, "R8 shadow unchanged");

    do_req(1, 16'hF830, 8'h11, K_ACK, 0, "R7 program start");
    do_req(0, 16'hF830, 0, K_NAK, 0, "R7 read while busy");
    do_req(1, 16'hF831, 8'h22, K_NAK, 0, "R7 write while busy");
    wait_idle();
    do_req(0, 16'hF831, 0, K_DAT, 8'hFF, "R7 busy write dropped");
    do_req(0, 16'hF830, 0, K_DAT, 8'h11, "R7 first program done");

    do_req(1, 16'hF800, 8'hA5, K_ACK, 0, "R10 program source");
    wait_idle();
    do_req(1, 16'h0000, 8'h12, K_ACK, 0, "R10 dirty shadow");
    do_req(1, 16'h00D8, 8'h01, K_ACK, 0, "R10 download request");
    busy_len(COPY_C, "R10 copy length");
    do_req(0, 16'h0000, 0, K_DAT, 8'hA5, "R10 shadow 0x00 reloaded");
    do_req(0, 16'h0010, 0, K_DAT, 8'hFF, "R10 shadow 0x10 reloaded");
    do_req(0, 16'h0090, 0, K_DAT, 8'hFF, "R10 shadow 0x90 reloaded");

    repeat (3) @(negedge clk);
    check("R11 all responses seen", 32'(expq.size()), 0);
    check("R4 prog_err sticky", 32'(prog_err), 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule